// File: doc/BRIEF.md
# Gamma Channel Refresh Sequencer

This block drives the periodic refresh of a fourteen-channel programmable reference generator. It derives a slow refresh clock, either by dividing the system clock down to about 21 kHz or by following an external clock that arrives on a shared bidirectional clock pin. Every falling edge of the chosen clock commits one channel: the block presents that channel's index and its 8-bit code, taken from one of two code banks, together with a one-cycle close strobe for the sample switch. Every rising edge produces a one-cycle open strobe. The channels are visited in a fixed repeating round, so a newly written code reaches its output only when its channel's turn comes.

Two control bits, captured on a configuration write, choose the clock source and an optional lag of about 3.5 µs between each clock edge and its strobe. With the internal source, the internal clock is driven out on the shared pin so other devices can follow it. That only happens after the first configuration write that selects the internal source, so the pin stays high-impedance after reset. A bank-select input picks bank A or bank B for all channels, so a whole gamma curve can be switched at once. The analog sample-and-hold is outside this block.

Top module: `chan_refresh_seq`

## Requirements
- R1: After reset `ch_idx` and `ch_code` are 0, `sw_close` and `sw_open` are 0, and `osc_oe` is 0 even though the internal source is selected and the internal clock runs on `osc_out`.
- R2: The internal clock on `osc_out` toggles every HALF_DIV = SYS_CLK_HZ/(2*INT_REF_HZ) system cycles. With the internal source selected, an open strobe follows a close strobe by HALF_DIV cycles and the next close strobe follows after another HALF_DIV cycles.
- R3: A falling edge of the selected refresh clock gives a one-cycle `sw_close` pulse. A rising edge gives a one-cycle `sw_open` pulse. The two never occur in the same cycle.
- R4: With the source bit at 1 (external), refresh follows `osc_in`. With the lag off, the strobe is high in the third cycle after a change of `osc_in`. The internal clock then produces no strobes.
- R5: `osc_oe` changes only on a configuration write (`cfg_wr`). A write with `cfg_ext_src`=0 sets it to 1 and a write with `cfg_ext_src`=1 clears it, in the cycle after the write.
- R6: With the lag bit at 1, every strobe comes LAG_CYC = (SYS_CLK_HZ/1000)*LAG_NS/1000000 cycles later than with the lag at 0.
- R7: Each close strobe commits one channel. The first commit after reset is channel 0, and later commits go 0, 1, ..., NUM_CH-1, then wrap to 0.
- R8: At a commit, `ch_code` is the code of channel `ch_idx`, taken from bits [k*CODE_W +: CODE_W] of `bank_a_codes` when the synchronised `bank_sel` is 0 and of `bank_b_codes` when it is 1.
- R9: `ch_idx` and `ch_code` hold between commits. A code change reaches `ch_code` only at that channel's next commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | One-cycle pulse: capture the two control bits |
| cfg_ext_src | input | 1 | Clock source bit: 0 internal, 1 external |
| cfg_lag_en | input | 1 | 1 delays every strobe by LAG_CYC cycles |
| bank_sel | input | 1 | Asynchronous bank choice: 0 bank A, 1 bank B |
| bank_a_codes | input | NUM_CH*CODE_W | Bank A codes, channel k at [k*CODE_W +: CODE_W] |
| bank_b_codes | input | NUM_CH*CODE_W | Bank B codes, same layout |
| osc_in | input | 1 | Input side of the shared clock pin |
| osc_out | output | 1 | Internal refresh clock to the shared pin |
| osc_oe | output | 1 | Output enable of the shared pin |
| ch_idx | output | $clog2(NUM_CH) | Channel committed by the last close strobe |
| ch_code | output | CODE_W | Code of that channel |
| sw_close | output | 1 | One-cycle strobe: commit the refresh |
| sw_open | output | 1 | One-cycle strobe: open the refresh switch |

## Verification
The assertions assume that the refresh clock is slow next to the system clock. Each half period of the external clock must be longer than LAG_CYC plus the three-cycle synchroniser path, so a lagged strobe never meets the strobe of the next edge, and `cfg_wr` is a single-cycle pulse. The bench holds each `osc_in` level for well over that many cycles and changes `bank_sel` and the codes only between commits. It runs the block with a small system-clock parameter, so the internal period and the lag come out as short, exactly computable cycle counts.

// File: rtl/crs_pkg.sv
package crs_pkg;

  typedef enum logic {
    SRC_INTERNAL = 1'b0,
    SRC_EXTERNAL = 1'b1
  } clk_src_e;

  // Half period of the internal refresh clock, in system cycles.
  function automatic int half_div(input int sys_hz, input int ref_hz);
    return sys_hz / (2 * ref_hz);
  endfunction

  // Strobe lag in system cycles for a lag given in nanoseconds.
  function automatic int lag_cycles(input int sys_hz, input int lag_ns);
    return ((sys_hz / 1000) * lag_ns) / 1000000;
  endfunction

endpackage

// File: rtl/crs_sync.sv
module crs_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q_sync <= '0;
    end else begin
      meta_q <= d_async;
      q_sync <= meta_q;
    end
  end
endmodule

// File: rtl/crs_int_osc.sv
module crs_int_osc #(
  parameter int HALF_DIV = 2380
) (
  input  logic clk,
  input  logic rst,
  output logic osc_lvl,
  output logic rise_ev,
  output logic fall_ev
);
  localparam int CW = $clog2(HALF_DIV + 1);

  logic [CW-1:0] div_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      osc_lvl <= 1'b0;
      rise_ev <= 1'b0;
      fall_ev <= 1'b0;
    end else begin
      rise_ev <= 1'b0;
      fall_ev <= 1'b0;
      if (div_cnt == CW'(HALF_DIV - 1)) begin
        div_cnt <= '0;
        osc_lvl <= ~osc_lvl;
        rise_ev <= ~osc_lvl;
        fall_ev <= osc_lvl;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

  // R2: the divider never passes its terminal count
  a_r2_div_bound: assert property (@(posedge clk) disable iff (rst)
    int'(div_cnt) < HALF_DIV);

  // R3: an edge is either rising or falling, never both
  a_r3_one_edge: assert property (@(posedge clk) disable iff (rst)
    !(rise_ev && fall_ev));

  // R2: the level only moves together with an edge event
  a_r2_lvl_moves_with_event: assert property (@(posedge clk) disable iff (rst)
    !$stable(osc_lvl) |-> (rise_ev || fall_ev));
endmodule

// File: rtl/crs_edge_lag.sv
module crs_edge_lag #(
  parameter int LAG_CYC = 350
) (
  input  logic clk,
  input  logic rst,
  input  logic lag_en,
  input  logic ev_in,
  output logic ev_out
);
  generate
    if (LAG_CYC == 0) begin : g_bypass
      logic unused_lag_en;
      assign unused_lag_en = lag_en;
      assign ev_out = ev_in;
    end else begin : g_count
      localparam int CW = $clog2(LAG_CYC + 1);
      logic [CW-1:0] lag_cnt;

      always_ff @(posedge clk) begin
        if (rst) begin
          lag_cnt <= '0;
        end else if (ev_in && lag_en) begin
          lag_cnt <= CW'(LAG_CYC);
        end else if (lag_cnt != '0) begin
          lag_cnt <= lag_cnt - 1'b1;
        end
      end

      assign ev_out = lag_en ? (lag_cnt == CW'(1)) : ev_in;

      // R6: the lag counter never exceeds its load value
      a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        int'(lag_cnt) <= LAG_CYC);

      // R6: a loaded counter runs down without reloading itself
      a_r6_count_down: assert property (@(posedge clk) disable iff (rst)
        (lag_cnt > CW'(1) && !ev_in) |=> (lag_cnt == $past(lag_cnt) - 1'b1));
    end
  endgenerate
endmodule

// File: rtl/crs_seq.sv
module crs_seq #(
  parameter int NUM_CH = 14,
  parameter int CODE_W = 8,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     close_ev,
  input  logic                     open_ev,
  input  logic                     use_bank_b,
  input  logic [NUM_CH*CODE_W-1:0] bank_a_codes,
  input  logic [NUM_CH*CODE_W-1:0] bank_b_codes,
  output logic [IDX_W-1:0]         ch_idx,
  output logic [CODE_W-1:0]        ch_code,
  output logic                     sw_close,
  output logic                     sw_open
);
  logic [CODE_W-1:0] code_a [NUM_CH];
  logic [CODE_W-1:0] code_b [NUM_CH];
  logic [IDX_W-1:0]  next_ptr;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
    assign code_a[g] = bank_a_codes[g*CODE_W +: CODE_W];
    assign code_b[g] = bank_b_codes[g*CODE_W +: CODE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      next_ptr <= '0;
      ch_idx   <= '0;
      ch_code  <= '0;
      sw_close <= 1'b0;
      sw_open  <= 1'b0;
    end else begin
      sw_close <= close_ev;
      sw_open  <= open_ev;
      if (close_ev) begin
        ch_idx   <= next_ptr;
        ch_code  <= use_bank_b ? code_b[next_ptr] : code_a[next_ptr];
        next_ptr <= (next_ptr == IDX_W'(NUM_CH - 1)) ? '0 : next_ptr + 1'b1;
      end
    end
  end

  // R7: the committed index stays inside the channel range
  a_r7_idx_range: assert property (@(posedge clk) disable iff (rst)
    int'(ch_idx) < NUM_CH);

  // R9: index and code only move together with a close strobe
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !sw_close |-> ($stable(ch_idx) && $stable(ch_code)));

  // R3: close and open strobes never coincide
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(sw_close && sw_open));

  // R3: strobes last exactly one cycle
  a_r3_close_pulse: assert property (@(posedge clk) disable iff (rst)
    sw_close |=> !sw_close);
  a_r3_open_pulse: assert property (@(posedge clk) disable iff (rst)
    sw_open |=> !sw_open);
endmodule

// File: rtl/chan_refresh_seq.sv
module chan_refresh_seq
  import crs_pkg::*;
#(
  parameter int NUM_CH     = 14,
  parameter int CODE_W     = 8,
  parameter int SYS_CLK_HZ = 100_000_000,
  parameter int INT_REF_HZ = 21_000,
  parameter int LAG_NS     = 3500,
  localparam int IDX_W     = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_wr,
  input  logic                     cfg_ext_src,
  input  logic                     cfg_lag_en,
  input  logic                     bank_sel,
  input  logic [NUM_CH*CODE_W-1:0] bank_a_codes,
  input  logic [NUM_CH*CODE_W-1:0] bank_b_codes,
  input  logic                     osc_in,
  output logic                     osc_out,
  output logic                     osc_oe,
  output logic [IDX_W-1:0]         ch_idx,
  output logic [CODE_W-1:0]        ch_code,
  output logic                     sw_close,
  output logic                     sw_open
);
  localparam int HALF_DIV = half_div(SYS_CLK_HZ, INT_REF_HZ);
  localparam int LAG_CYC  = lag_cycles(SYS_CLK_HZ, LAG_NS);

  // Control bits captured on a configuration write
  clk_src_e src_q;
  logic     lag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= SRC_INTERNAL;
      lag_q  <= 1'b0;
      osc_oe <= 1'b0;
    end else if (cfg_wr) begin
      src_q  <= clk_src_e'(cfg_ext_src);
      lag_q  <= cfg_lag_en;
      osc_oe <= ~cfg_ext_src;
    end
  end

  // Internal divided clock
  logic int_rise, int_fall;

  crs_int_osc #(.HALF_DIV(HALF_DIV)) u_int_osc (
    .clk     (clk),
    .rst     (rst),
    .osc_lvl (osc_out),
    .rise_ev (int_rise),
    .fall_ev (int_fall)
  );

  // External clock: synchronise, then detect edges
  logic ext_s, ext_d;
  logic ext_rise, ext_fall;

  crs_sync #(.WIDTH(1)) u_ext_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (osc_in),
    .q_sync  (ext_s)
  );

  always_ff @(posedge clk) begin
    if (rst) ext_d <= 1'b0;
    else     ext_d <= ext_s;
  end

  assign ext_rise = ext_s & ~ext_d;
  assign ext_fall = ~ext_s & ext_d;

  // Bank choice synchronised as well
  logic bank_b_s;

  crs_sync #(.WIDTH(1)) u_bank_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (bank_sel),
    .q_sync  (bank_b_s)
  );

  // Source selection; index 0 commits, index 1 opens the switch
  logic [1:0] ev_raw, ev_lag;

  assign ev_raw[0] = (src_q == SRC_EXTERNAL) ? ext_fall : int_fall;
  assign ev_raw[1] = (src_q == SRC_EXTERNAL) ? ext_rise : int_rise;

  for (genvar e = 0; e < 2; e++) begin : g_edge
    crs_edge_lag #(.LAG_CYC(LAG_CYC)) u_lag (
      .clk    (clk),
      .rst    (rst),
      .lag_en (lag_q),
      .ev_in  (ev_raw[e]),
      .ev_out (ev_lag[e])
    );
  end

  crs_seq #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .close_ev     (ev_lag[0]),
    .open_ev      (ev_lag[1]),
    .use_bank_b   (bank_b_s),
    .bank_a_codes (bank_a_codes),
    .bank_b_codes (bank_b_codes),
    .ch_idx       (ch_idx),
    .ch_code      (ch_code),
    .sw_close     (sw_close),
    .sw_open      (sw_open)
  );

  // R5: the pin direction changes only on a configuration write
  a_r5_oe_write_only: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |=> $stable(osc_oe));

  // R4: the pin never drives while the external source is in use
  a_r4_oe_not_ext: assert property (@(posedge clk) disable iff (rst)
    osc_oe |-> (src_q == SRC_INTERNAL));

  // R6: with the lag off, a commit event reaches the strobe on the next edge
  a_r6_bypass_close: assert property (@(posedge clk) disable iff (rst)
    (!lag_q && ev_raw[0]) |=> sw_close);
endmodule

// File: tb/chan_refresh_seq_tb_top.sv
module chan_refresh_seq_tb_top;
  localparam int NUM_CH = 14;
  localparam int CODE_W = 8;
  localparam int SYS_HZ = 1_000_000;
  localparam int REF_HZ = 21_000;
  localparam int LAGNS  = 3500;
  localparam int HALF   = SYS_HZ / (2 * REF_HZ);
  localparam int LAGC   = ((SYS_HZ / 1000) * LAGNS) / 1000000;
  localparam int IDX_W  = $clog2(NUM_CH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 1'b0, cfg_ext_src = 1'b0, cfg_lag_en = 1'b0;
  logic bank_sel = 1'b0, osc_in = 1'b1;
  logic [NUM_CH*CODE_W-1:0] bank_a, bank_b;
  logic osc_out, osc_oe, sw_close, sw_open;
  logic [IDX_W-1:0]  ch_idx;
  logic [CODE_W-1:0] ch_code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  chan_refresh_seq #(
    .NUM_CH(NUM_CH), .CODE_W(CODE_W), .SYS_CLK_HZ(SYS_HZ),
    .INT_REF_HZ(REF_HZ), .LAG_NS(LAGNS)
  ) dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_ext_src(cfg_ext_src),
    .cfg_lag_en(cfg_lag_en), .bank_sel(bank_sel), .bank_a_codes(bank_a),
    .bank_b_codes(bank_b), .osc_in(osc_in), .osc_out(osc_out),
    .osc_oe(osc_oe), .ch_idx(ch_idx), .ch_code(ch_code),
    .sw_close(sw_close), .sw_open(sw_open)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int code_a(input int k); return 8'h10 + k; endfunction
  function automatic int code_b(input int k); return 8'hA0 + k; endfunction

  task automatic do_reset();
    for (int k = 0; k < NUM_CH; k++) begin
      bank_a[k*CODE_W +: CODE_W] = CODE_W'(code_a(k));
      bank_b[k*CODE_W +: CODE_W] = CODE_W'(code_b(k));
    end
    rst = 1'b1; osc_in = 1'b1; bank_sel = 1'b0; cfg_wr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic write_cfg(input logic ext, input logic lag);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_ext_src = ext; cfg_lag_en = lag;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // Change osc_in, count cycles until the wanted strobe is seen (99 = none)
  task automatic ext_edge(input logic lvl, input bit want_close, output int lat);
    @(negedge clk);
    osc_in = lvl;
    lat = 99;
    for (int n = 1; n <= 60; n++) begin
      @(posedge clk);
      @(negedge clk);
      if (want_close ? sw_close : sw_open) begin
        lat = n;
        break;
      end
    end
  endtask

  // From the current negedge, cycles until the wanted strobe (99 = none)
  task automatic wait_strobe(input bit want_close, input int limit, output int n_out);
    n_out = 99;
    for (int n = 1; n <= limit; n++) begin
      @(posedge clk);
      @(negedge clk);
      if (want_close ? sw_close : sw_open) begin
        n_out = n;
        break;
      end
    end
  endtask

  task automatic t_reset();
    bit toggled = 1'b0;
    logic first;
    do_reset();
    chk("R1", "ch_idx after reset", int'(ch_idx), 0);
    chk("R1", "ch_code after reset", int'(ch_code), 0);
    chk("R1", "sw_close after reset", int'(sw_close), 0);
    chk("R1", "sw_open after reset", int'(sw_open), 0);
    first = osc_out;
    for (int n = 0; n < 3 * HALF; n++) begin
      @(negedge clk);
      if (osc_out != first) toggled = 1'b1;
    end
    chk("R1", "internal clock runs on osc_out", int'(toggled), 1);
    chk("R1", "osc_oe stays low without a write", int'(osc_oe), 0);
  endtask

  task automatic t_internal();
    int n;
    do_reset();
    wait_strobe(1'b1, 4 * HALF, n);
    chk("R7", "first commit index", int'(ch_idx), 0);
    chk("R8", "first commit code bank A", int'(ch_code), code_a(0));
    wait_strobe(1'b0, 4 * HALF, n);
    chk("R2", "close to open cycles", n, HALF);
    wait_strobe(1'b1, 4 * HALF, n);
    chk("R2", "open to close cycles", n, HALF);
    chk("R7", "second commit index", int'(ch_idx), 1);
    write_cfg(1'b0, 1'b0);
    chk("R5", "osc_oe after internal-source write", int'(osc_oe), 1);
    begin
      logic prev;
      int cnt = 0;
      @(negedge clk);
      prev = osc_out;
      while (osc_out == prev && cnt < 4 * HALF) begin @(negedge clk); cnt++; end
      prev = osc_out; cnt = 0;
      while (osc_out == prev && cnt < 4 * HALF) begin @(negedge clk); cnt++; end
      chk("R2", "osc_out half period", cnt, HALF);
    end
  endtask

  task automatic t_ext_order();
    int lat;
    int seen = 0;
    do_reset();
    write_cfg(1'b1, 1'b0);
    chk("R5", "osc_oe after external-source write", int'(osc_oe), 0);
    repeat (6) @(negedge clk);
    for (int i = 0; i <= NUM_CH; i++) begin
      ext_edge(1'b0, 1'b1, lat);
      if (i == 0) chk("R4", "external fall latency", lat, 3);
      chk("R7", "commit order index", int'(ch_idx), i % NUM_CH);
      chk("R8", "bank A code for index", int'(ch_code), code_a(i % NUM_CH));
      ext_edge(1'b1, 1'b0, lat);
      if (i == 0) chk("R3", "external rise gives open strobe", lat, 3);
    end
    for (int n = 0; n < 6 * HALF; n++) begin
      @(negedge clk);
      if (sw_close || sw_open) seen++;
    end
    chk("R4", "internal clock ignored in external mode", seen, 0);
  endtask

  task automatic t_bank();
    int lat;
    logic [IDX_W-1:0] held_idx;
    logic [CODE_W-1:0] held_code;
    // next commit after t_ext_order is channel 1
    @(negedge clk);
    bank_sel = 1'b1;
    bank_b[1*CODE_W +: CODE_W] = 8'h5C;
    held_idx = ch_idx; held_code = ch_code;
    repeat (8) @(negedge clk);
    chk("R9", "index held between commits", int'(ch_idx), int'(held_idx));
    chk("R9", "code held after bank change", int'(ch_code), int'(held_code));
    ext_edge(1'b0, 1'b1, lat);
    chk("R8", "bank B index", int'(ch_idx), 1);
    chk("R9", "new code at its commit", int'(ch_code), 8'h5C);
    ext_edge(1'b1, 1'b0, lat);
    ext_edge(1'b0, 1'b1, lat);
    chk("R8", "bank B code channel 2", int'(ch_code), code_b(2));
    ext_edge(1'b1, 1'b0, lat);
  endtask

  task automatic t_lag();
    int lat;
    write_cfg(1'b1, 1'b1);
    repeat (4) @(negedge clk);
    ext_edge(1'b0, 1'b1, lat);
    chk("R6", "lagged close latency", lat, 3 + LAGC);
    ext_edge(1'b1, 1'b0, lat);
    chk("R6", "lagged open latency", lat, 3 + LAGC);
    write_cfg(1'b1, 1'b0);
    repeat (4) @(negedge clk);
    ext_edge(1'b0, 1'b1, lat);
    chk("R6", "bypassed close latency", lat, 3);
    ext_edge(1'b1, 1'b0, lat);
  endtask

  task automatic t_oe();
    write_cfg(1'b0, 1'b0);
    chk("R5", "oe set by internal write", int'(osc_oe), 1);
    repeat (5) @(negedge clk);
    chk("R5", "oe holds without write", int'(osc_oe), 1);
    write_cfg(1'b1, 1'b0);
    chk("R5", "oe cleared by external write", int'(osc_oe), 0);
  endtask

  initial begin
    t_reset();
    t_internal();
    t_ext_order();
    t_bank();
    t_lag();
    t_oe();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule